// File: doc/BRIEF.md
# Load Miss Criticality Tracker

This block keeps a small file of holding registers for load misses that are still waiting on the next memory level. A load that misses is given a free entry, and the entry records the missing line address. While the miss is open, the instruction window reports each new instruction that comes to depend on that load. The entry counts these reports and also keeps a sticky flag that is set if any dependent is a branch. Dependents that joined before the cache access are never reported here, so only growth during the miss counts.

When the fill data returns, its address is matched against the open entries in the same cycle. The block gives a verdict that sends the line either to the main data cache (critical) or to the small side buffer (non-critical), and the entry is freed. A probe port lets the cache report a hit for a line whose miss is still open. The threshold is an input, so the best setting found in practice can be applied: threshold zero, where one or more dependents makes a line critical.

Top module: `miss_dep_tracker`

## Requirements
- R1: With allocValid high and at least one entry free, allocIdx shows the lowest-numbered free entry in the same cycle. From the next cycle that entry holds allocAddr, a count of zero and a clear branch flag.
- R2: allocFull is high exactly when all 8 entries are in use. An allocation request made while full changes no entry.
- R3: A dependency event (depValid) naming an in-use entry adds one to that entry's count at the clock edge.
- R4: A count stops at its maximum (7 for the default 3-bit counter) and never wraps to zero.
- R5: A dependency event naming an entry that is not in use changes nothing.
- R6: With fillValid high and fillAddr equal to an in-use entry's address, fillCritical is high in the same cycle exactly when the entry's count is above critThresh (unsigned) or its branch flag is set. A dependency event in the same cycle as the fill is not counted.
- R7: After a dependency event with depIsBranch high, the entry's verdict is critical whatever its count or the threshold.
- R8: A matched fill frees its entry from the next cycle on, and later allocations may reuse it.
- R9: A fill whose address matches no in-use entry raises fillNoMatch, gives fillCritical high, and changes no entry.
- R10: probeHit is high in the same cycle when probeAddr equals the address of an in-use entry.
- R11: After reset every entry is free: allocFull, probeHit and fillNoMatch are low and allocIdx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| critThresh | input | CNT_W | Count that must be exceeded for a critical verdict |
| allocValid | input | 1 | Request to record a new load miss |
| allocAddr | input | AW | Line address of the new miss |
| allocIdx | output | IDX_W | Entry granted to the request |
| allocFull | output | 1 | No entry is free; the request is refused |
| depValid | input | 1 | A new dependent instruction was added to a missing load |
| depIdx | input | IDX_W | Entry of the load that gained a dependent |
| depIsBranch | input | 1 | The new dependent is a branch |
| fillValid | input | 1 | Fill data returned this cycle |
| fillAddr | input | AW | Line address of the fill |
| fillCritical | output | 1 | Verdict: 1 = main cache, 0 = side buffer |
| fillNoMatch | output | 1 | The fill matched no open entry |
| probeAddr | input | AW | Address of a cache access to test against open misses |
| probeHit | output | 1 | The probed line has a miss outstanding |

## Verification
A wrong count or a lost branch flag stays hidden until the fill for that entry returns. Then it shows as a flipped fillCritical in that cycle. The sweep therefore ends every dependency pattern with a fill and steps the threshold across the whole counter range, so an off-by-one, a wrap or a missed increment flips a verdict. A wrong valid bit shows at once on probeHit, allocIdx or allocFull, or as a false fillNoMatch on the next fill.

// File: rtl/mdt_pkg.sv
package mdt_pkg;

  // Strobes from the control half to the entry datapath
  typedef struct packed {
    logic allocEn;
    logic freeEn;
    logic depEn;
    logic depBr;
  } mdt_strobe_t;

endpackage

// File: rtl/mdt_entries.sv
module mdt_entries
  import mdt_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned AW          = 16,
  parameter int unsigned CNT_W       = 3,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  mdt_strobe_t            st,
  input  logic [IDX_W-1:0]       allocIdx,
  input  logic [AW-1:0]          allocAddr,
  input  logic [IDX_W-1:0]       freeIdx,
  input  logic [IDX_W-1:0]       depIdx,
  input  logic [AW-1:0]          fillAddr,
  input  logic [AW-1:0]          probeAddr,
  input  logic [CNT_W-1:0]       critThresh,
  output logic [NUM_ENTRIES-1:0] validVec,
  output logic [NUM_ENTRIES-1:0] fillHitVec,
  output logic [NUM_ENTRIES-1:0] critVec,
  output logic                   probeHit
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_ENTRIES-1:0] probeHitVec;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic             valid;
    logic [AW-1:0]    addr;
    logic [CNT_W-1:0] cnt;
    logic             brSeen;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        valid  <= 1'b0;
        addr   <= '0;
        cnt    <= '0;
        brSeen <= 1'b0;
      end else if (st.allocEn && allocIdx == IDX_W'(e)) begin
        valid  <= 1'b1;
        addr   <= allocAddr;
        cnt    <= '0;
        brSeen <= 1'b0;
      end else if (st.freeEn && freeIdx == IDX_W'(e)) begin
        valid  <= 1'b0;
      end else if (st.depEn && depIdx == IDX_W'(e) && valid) begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        brSeen <= brSeen | st.depBr;
      end
    end

    assign validVec[e]    = valid;
    assign fillHitVec[e]  = valid && (addr == fillAddr);
    assign probeHitVec[e] = valid && (addr == probeAddr);
    assign critVec[e]     = brSeen || (cnt > critThresh);
  end

  assign probeHit = |probeHitVec;

endmodule

// File: rtl/mdt_ctrl.sv
module mdt_ctrl
  import mdt_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   allocValid,
  input  logic                   depValid,
  input  logic [IDX_W-1:0]       depIdx,
  input  logic                   depIsBranch,
  input  logic                   fillValid,
  input  logic [NUM_ENTRIES-1:0] validVec,
  input  logic [NUM_ENTRIES-1:0] fillHitVec,
  input  logic [NUM_ENTRIES-1:0] critVec,
  output mdt_strobe_t            st,
  output logic [IDX_W-1:0]       allocIdx,
  output logic [IDX_W-1:0]       freeIdx,
  output logic                   allocFull,
  output logic                   fillCritical,
  output logic                   fillNoMatch
);

  logic anyFree;
  logic anyMatch;

  // Lowest-numbered free entry
  always_comb begin
    anyFree  = 1'b0;
    allocIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        anyFree  = 1'b1;
        allocIdx = IDX_W'(i);
      end
    end
  end

  // Lowest-numbered entry matching the fill
  always_comb begin
    anyMatch = 1'b0;
    freeIdx  = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (fillHitVec[i]) begin
        anyMatch = 1'b1;
        freeIdx  = IDX_W'(i);
      end
    end
  end

  assign allocFull    = !anyFree;
  assign fillNoMatch  = fillValid && !anyMatch;
  assign fillCritical = fillValid && (anyMatch ? critVec[freeIdx] : 1'b1);

  always_comb begin
    st.allocEn = allocValid && anyFree;
    st.freeEn  = fillValid && anyMatch;
    st.depEn   = depValid && validVec[depIdx];
    st.depBr   = depIsBranch;
  end

endmodule

// File: rtl/miss_dep_tracker.sv
module miss_dep_tracker
  import mdt_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned AW          = 16,
  parameter int unsigned CNT_W       = 3,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] critThresh,
  input  logic             allocValid,
  input  logic [AW-1:0]    allocAddr,
  output logic [IDX_W-1:0] allocIdx,
  output logic             allocFull,
  input  logic             depValid,
  input  logic [IDX_W-1:0] depIdx,
  input  logic             depIsBranch,
  input  logic             fillValid,
  input  logic [AW-1:0]    fillAddr,
  output logic             fillCritical,
  output logic             fillNoMatch,
  input  logic [AW-1:0]    probeAddr,
  output logic             probeHit
);

  mdt_strobe_t            st;
  logic [IDX_W-1:0]       freeIdx;
  logic [NUM_ENTRIES-1:0] validVec;
  logic [NUM_ENTRIES-1:0] fillHitVec;
  logic [NUM_ENTRIES-1:0] critVec;

  mdt_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .allocValid  (allocValid),
    .depValid    (depValid),
    .depIdx      (depIdx),
    .depIsBranch (depIsBranch),
    .fillValid   (fillValid),
    .validVec    (validVec),
    .fillHitVec  (fillHitVec),
    .critVec     (critVec),
    .st          (st),
    .allocIdx    (allocIdx),
    .freeIdx     (freeIdx),
    .allocFull   (allocFull),
    .fillCritical(fillCritical),
    .fillNoMatch (fillNoMatch)
  );

  mdt_entries #(.NUM_ENTRIES(NUM_ENTRIES), .AW(AW), .CNT_W(CNT_W)) u_entries (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .allocIdx   (allocIdx),
    .allocAddr  (allocAddr),
    .freeIdx    (freeIdx),
    .depIdx     (depIdx),
    .fillAddr   (fillAddr),
    .probeAddr  (probeAddr),
    .critThresh (critThresh),
    .validVec   (validVec),
    .fillHitVec (fillHitVec),
    .critVec    (critVec),
    .probeHit   (probeHit)
  );

endmodule

// File: rtl/mdt_checker.sv
module mdt_checker #(
  parameter int unsigned NUM_ENTRIES = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_ENTRIES-1:0] validVec,
  input logic                   allocValid,
  input logic                   allocFull,
  input logic [IDX_W-1:0]       allocIdx,
  input logic                   fillValid,
  input logic                   fillNoMatch,
  input logic                   fillCritical
);

  AST_FULL_ALL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    allocFull == (&validVec)); // R2

  AST_GRANT_IS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && !allocFull) |-> !validVec[allocIdx]); // R1

  AST_GRANT_TAKES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && !allocFull) |=> validVec[$past(allocIdx)]); // R1

  AST_NOMATCH_CRITICAL: assert property (@(posedge clk) disable iff (!rstN)
    fillNoMatch |-> (fillCritical && fillValid)); // R9

  AST_NOMATCH_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (fillNoMatch && !allocValid) |=> $stable(validVec)); // R9

  AST_FILL_FREES: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !fillNoMatch && !(allocValid && !allocFull))
      |=> ($countones(validVec) + 1 == $past($countones(validVec)))); // R8

endmodule

bind miss_dep_tracker mdt_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_mdt_checker (
  .clk         (clk),
  .rstN        (rstN),
  .validVec    (validVec),
  .allocValid  (allocValid),
  .allocFull   (allocFull),
  .allocIdx    (allocIdx),
  .fillValid   (fillValid),
  .fillNoMatch (fillNoMatch),
  .fillCritical(fillCritical)
);

// File: tb/test_miss_dep_tracker.sv
module test_miss_dep_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int AW  = 16;
  localparam int CW  = 3;
  localparam int IW  = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] critThresh = '0;
  logic          allocValid = 1'b0;
  logic [AW-1:0] allocAddr = '0;
  logic [IW-1:0] allocIdx;
  logic          allocFull;
  logic          depValid = 1'b0;
  logic [IW-1:0] depIdx = '0;
  logic          depIsBranch = 1'b0;
  logic          fillValid = 1'b0;
  logic [AW-1:0] fillAddr = '0;
  logic          fillCritical;
  logic          fillNoMatch;
  logic [AW-1:0] probeAddr = '0;
  logic          probeHit;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  miss_dep_tracker #(.NUM_ENTRIES(N), .AW(AW), .CNT_W(CW)) i_miss_dep_tracker (
    .clk(clk), .rstN(rstN), .critThresh(critThresh),
    .allocValid(allocValid), .allocAddr(allocAddr), .allocIdx(allocIdx), .allocFull(allocFull),
    .depValid(depValid), .depIdx(depIdx), .depIsBranch(depIsBranch),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillCritical(fillCritical), .fillNoMatch(fillNoMatch),
    .probeAddr(probeAddr), .probeHit(probeHit)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // Each operation: drive after the falling edge, check before the rising edge
  task automatic doAlloc(input int addr, input int expIdx, input int expFull, input string req);
    @(negedge clk);
    allocValid = 1'b1; allocAddr = AW'(addr);
    #1;
    check({req, " allocFull"}, int'(allocFull), expFull);
    if (expFull == 0) check({req, " allocIdx"}, int'(allocIdx), expIdx);
    @(posedge clk); #1;
    allocValid = 1'b0;
  endtask

  task automatic doDep(input int idx, input bit br);
    @(negedge clk);
    depValid = 1'b1; depIdx = IW'(idx); depIsBranch = br;
    @(posedge clk); #1;
    depValid = 1'b0; depIsBranch = 1'b0;
  endtask

  task automatic doFill(input int addr, input int expCrit, input int expNoMatch, input string req);
    @(negedge clk);
    fillValid = 1'b1; fillAddr = AW'(addr);
    #1;
    check({req, " fillCritical"}, int'(fillCritical), expCrit);
    check({req, " fillNoMatch"}, int'(fillNoMatch), expNoMatch);
    @(posedge clk); #1;
    fillValid = 1'b0;
  endtask

  task automatic doProbe(input int addr, input int exp, input string req);
    @(negedge clk);
    probeAddr = AW'(addr);
    #1;
    check({req, " probeHit"}, int'(probeHit), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R11 reset state
    #1;
    check("R11 allocFull", int'(allocFull), 0);
    check("R11 allocIdx", int'(allocIdx), 0);
    check("R11 fillNoMatch", int'(fillNoMatch), 0);
    doProbe(0, 0, "R11");

    // R3 R4 R6 R7 sweep: every threshold, 0..9 dependents, with and without a branch
    for (int thr = 0; thr <= CMAX; thr++) begin
      for (int n = 0; n <= CMAX + 2; n++) begin
        for (int br = 0; br < 2; br++) begin
          int sat;
          int exp;
          if (br == 1 && n == 0) continue;
          critThresh = CW'(thr);
          doAlloc(16'h0400 + n, 0, 0, "R1 sweep");
          doProbe(16'h0400 + n, 1, "R10 sweep");
          for (int k = 0; k < n; k++) doDep(0, (br == 1) && (k == 0));
          sat = (n > CMAX) ? CMAX : n;
          exp = ((br == 1) || (sat > thr)) ? 1 : 0;
          doFill(16'h0400 + n, exp, 0, (n > CMAX) ? "R4 sweep" : ((br == 1) ? "R7 sweep" : "R3 R6 sweep"));
          doProbe(16'h0400 + n, 0, "R8 sweep");
        end
      end
    end

    // R1 R2 fill all entries in order
    critThresh = '0;
    for (int i = 0; i < N; i++) doAlloc(16'h1000 + i, i, 0, "R1 fill-up");
    doAlloc(16'h2000, 0, 1, "R2 full");
    doProbe(16'h2000, 0, "R2 refused alloc");
    doProbe(16'h1003, 1, "R10 open miss");

    // R5 dependency to a free entry: free entry 6, poke it, reallocate, verdict must be clean
    doFill(16'h1006, 0, 0, "R8 free");
    doProbe(16'h1006, 0, "R8 freed");
    doDep(6, 1'b1);
    doDep(6, 1'b0);
    doAlloc(16'h3006, 6, 0, "R8 reuse");
    doFill(16'h3006, 0, 0, "R5 ignored dep");
    doAlloc(16'h3106, 6, 0, "R1 reuse again");

    // R9 unmatched fill keeps everything
    doFill(16'h7777, 1, 1, "R9 no match");
    #1 check("R9 still full", int'(allocFull), 1);
    doProbe(16'h1000, 1, "R9 entries kept");

    // R6 dependency in the fill cycle is not counted
    @(negedge clk);
    fillValid = 1'b1; fillAddr = 16'h1000; depValid = 1'b1; depIdx = 0;
    #1;
    check("R6 same-cycle dep fillCritical", int'(fillCritical), 0);
    @(posedge clk); #1;
    fillValid = 1'b0; depValid = 1'b0;

    // R7 sticky branch over later plain deps with the top threshold
    critThresh = CW'(CMAX);
    doDep(1, 1'b1);
    doDep(1, 1'b0);
    doDep(1, 1'b0);
    doFill(16'h1001, 1, 0, "R7 sticky branch");
    doFill(16'h1002, 0, 0, "R6 top threshold");

    repeat (2) @(posedge clk);
    finishRun();
  end

endmodule